// File: doc/BRIEF.md
# 1-Wire Bus Reset and Presence Sequencer

This block is the reset engine of a 1-Wire master. A one-cycle `start` strobe begins a reset sequence at the speed given by `speed`. The block asserts `bus_pull_en`, which enables an external open-drain transistor that holds the bus low. It then releases the bus and samples `bus_in` at fixed offsets. All segment lengths are counted in ticks of a 1 µs enable, `tick_us`, so the system clock frequency does not affect the bus timing.

After the bus is released, the first sample looks for a short or an interrupt. If the line is already high there, a second sample at a later offset looks for a presence pulse. A fill period follows, and then the block reports. If the line is low at the first sample, the block waits a long recheck delay and samples again. A line that is still low is reported at once as a short. A line that has recovered means a slave signalled an interrupt: the block waits the fill time and reports an alarming presence. The result is presented with a one-cycle `done` strobe and is held until the next report.

The controller has seven states. IDLE moves to RST_LOW on `start`. RST_LOW moves to SI_WAIT when the low time expires. SI_WAIT moves to PD_WAIT if the sample is high and to RECHECK if it is low. PD_WAIT always moves to FILL. RECHECK moves to FILL if the sample is high and to REPORT if it is low. FILL moves to REPORT when the fill time expires. REPORT always returns to IDLE.

Top module: `ow_reset_seq`

## Requirements
- R1: A `start` seen in IDLE latches `speed` and asserts `bus_pull_en` from the next cycle. The enable stays high for exactly the low time, counted in `tick_us` ticks: 64 ticks at overdrive (`speed`=01) and 512 ticks at every other code (00 regular, 10 flexible, 11 treated as regular). `bus_pull_en` is never high in any other phase.
- R2: The short/interrupt sample is taken on the 8th tick after release (2nd tick at overdrive).
- R3: If the short/interrupt sample is high, the presence sample is taken a further 64 ticks later (8 at overdrive). A low presence sample gives result 2'b00, which means presence. A high presence sample gives 2'b10, which means no presence.
- R4: On the presence path, `done` follows the presence sample only after a fill of 512 ticks (64 at overdrive), whatever the sample showed.
- R5: If the short/interrupt sample is low, the bus is sampled again after RECHECK_TICKS ticks (parameter, default 4096).
- R6: A low recheck sample gives result 2'b11 (short), with `done` on the cycle after that tick and no fill wait.
- R7: A high recheck sample leads to the fill time and then result 2'b01 (alarming presence), with no presence sample taken.
- R8: The short/interrupt check and the recheck run the same way at overdrive speed.
- R9: `start` has no effect while `busy` is high, and changes of `speed` after the start cycle do not alter the running sequence.
- R10: `done` is high for exactly one cycle. `result` changes only in a `done` cycle. `busy` is high from the cycle after start through the `done` cycle and low after it.
- R11: After reset, `bus_pull_en`, `busy` and `done` are 0 and `result` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| start | input | 1 | Begin a reset sequence (used only when idle) |
| speed | input | 2 | Speed select: 00 regular, 01 overdrive, 10 flexible, 11 regular |
| bus_in | input | 1 | Synchronised level of the 1-Wire line |
| bus_pull_en | output | 1 | Enables the open-drain pull-down of the line |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle strobe: result is valid |
| result | output | 2 | 00 presence, 01 alarming presence, 10 no presence, 11 short |

## Verification
The bench targets the tick on which each sample is taken. It uses presence windows that end one tick before, or start exactly on, the presence sample point. A design sampling one tick off would report the wrong one of presence and no presence. Single-tick low pulses placed on, and just before, the short/interrupt sample point show whether that sample is taken at the right offset. A mistimed sample would send the sequence down the wrong path. An interrupt that ends one tick before the recheck, and a line that is still low at the recheck, separate alarming presence from short. The bench also counts the ticks from release to `done`. A design that waits the fill after a short, or skips it after an alarm, changes that count. Extra starts and speed changes during a sequence show whether the design restarts or picks up the new speed mid-sequence.

// File: rtl/ow_rst_pkg.sv
package ow_rst_pkg;

    typedef enum logic [1:0] {
        SPD_STD  = 2'd0,
        SPD_OVD  = 2'd1,
        SPD_FLEX = 2'd2,
        SPD_ALT  = 2'd3
    } ow_speed_e;

    typedef enum logic [1:0] {
        RES_PRESENT = 2'd0,
        RES_ALARM   = 2'd1,
        RES_EMPTY   = 2'd2,
        RES_SHORT   = 2'd3
    } ow_result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_SI_WAIT,
        ST_PD_WAIT,
        ST_RECHECK,
        ST_FILL,
        ST_REPORT
    } ow_state_e;

    typedef enum logic [2:0] {
        PH_LOW,
        PH_SI,
        PH_PD,
        PH_RECHK,
        PH_FILL
    } ow_phase_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ow_rst_durations.sv
module ow_rst_durations
    import ow_rst_pkg::*;
#(
    parameter int unsigned LOW_STD  = 512,
    parameter int unsigned LOW_OVD  = 64,
    parameter int unsigned SI_STD   = 8,
    parameter int unsigned SI_OVD   = 2,
    parameter int unsigned PD_STD   = 64,
    parameter int unsigned PD_OVD   = 8,
    parameter int unsigned FILL_STD = 512,
    parameter int unsigned FILL_OVD = 64,
    parameter int unsigned RECHECK  = 4096,
    parameter int unsigned CNT_W    = 13
) (
    input  ow_speed_e        speed_i,
    input  ow_phase_e        phase_i,
    output logic [CNT_W-1:0] limit_o
);

    // Overdrive is the only code with its own timing; all other codes
    // share the regular set.
    logic fast;
    assign fast = (speed_i == SPD_OVD);

    always_comb begin
        unique case (phase_i)
            PH_LOW:   limit_o = fast ? CNT_W'(LOW_OVD)  : CNT_W'(LOW_STD);
            PH_SI:    limit_o = fast ? CNT_W'(SI_OVD)   : CNT_W'(SI_STD);
            PH_PD:    limit_o = fast ? CNT_W'(PD_OVD)   : CNT_W'(PD_STD);
            PH_RECHK: limit_o = CNT_W'(RECHECK);
            PH_FILL:  limit_o = fast ? CNT_W'(FILL_OVD) : CNT_W'(FILL_STD);
            default:  limit_o = CNT_W'(LOW_STD);
        endcase
    end

endmodule

// File: rtl/ow_rst_timer.sv
module ow_rst_timer #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    // Expires on the tick that completes the segment.
    assign expire_o = tick_i && (cnt_q == limit_i - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R1: the segment counter never runs past the limit picked for its phase
    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit_i);

endmodule

// File: rtl/ow_reset_seq.sv
module ow_reset_seq
    import ow_rst_pkg::*;
#(
    parameter int unsigned LOW_STD       = 512,
    parameter int unsigned LOW_OVD       = 64,
    parameter int unsigned SI_STD        = 8,
    parameter int unsigned SI_OVD        = 2,
    parameter int unsigned PD_STD        = 64,
    parameter int unsigned PD_OVD        = 8,
    parameter int unsigned FILL_STD      = 512,
    parameter int unsigned FILL_OVD      = 64,
    parameter int unsigned RECHECK_TICKS = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       start,
    input  logic [1:0] speed,
    input  logic       bus_in,
    output logic       bus_pull_en,
    output logic       busy,
    output logic       done,
    output logic [1:0] result
);

    localparam int unsigned MAX_DUR = umax(umax(umax(LOW_STD, LOW_OVD), umax(FILL_STD, FILL_OVD)),
                                           umax(umax(SI_STD, SI_OVD), umax(umax(PD_STD, PD_OVD), RECHECK_TICKS)));
    localparam int unsigned CNT_W = $clog2(MAX_DUR + 1);

    ow_state_e        state_q, state_d;
    ow_speed_e        spd_q, spd_d;
    ow_result_e       res_q, res_d;
    ow_result_e       pend_q, pend_d;
    ow_phase_e        phase;
    logic [CNT_W-1:0] limit;
    logic             expire;
    logic             clr;

    // Phase selection for the duration table
    always_comb begin
        unique case (state_q)
            ST_RST_LOW: phase = PH_LOW;
            ST_SI_WAIT: phase = PH_SI;
            ST_PD_WAIT: phase = PH_PD;
            ST_RECHECK: phase = PH_RECHK;
            ST_FILL:    phase = PH_FILL;
            default:    phase = PH_LOW;
        endcase
    end

    ow_rst_durations #(
        .LOW_STD (LOW_STD),
        .LOW_OVD (LOW_OVD),
        .SI_STD  (SI_STD),
        .SI_OVD  (SI_OVD),
        .PD_STD  (PD_STD),
        .PD_OVD  (PD_OVD),
        .FILL_STD(FILL_STD),
        .FILL_OVD(FILL_OVD),
        .RECHECK (RECHECK_TICKS),
        .CNT_W   (CNT_W)
    ) u_dur (
        .speed_i(spd_q),
        .phase_i(phase),
        .limit_o(limit)
    );

    assign clr = expire || (state_q == ST_IDLE) || (state_q == ST_REPORT);

    ow_rst_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_us),
        .clr_i   (clr),
        .limit_i (limit),
        .expire_o(expire)
    );

    // Next-state and result decisions
    always_comb begin
        state_d = state_q;
        spd_d   = spd_q;
        res_d   = res_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    spd_d   = ow_speed_e'(speed);
                    state_d = ST_RST_LOW;
                end
            end
            ST_RST_LOW: begin
                if (expire) state_d = ST_SI_WAIT;
            end
            ST_SI_WAIT: begin
                if (expire) state_d = bus_in ? ST_PD_WAIT : ST_RECHECK;
            end
            ST_PD_WAIT: begin
                if (expire) begin
                    pend_d  = bus_in ? RES_EMPTY : RES_PRESENT;
                    state_d = ST_FILL;
                end
            end
            ST_RECHECK: begin
                if (expire) begin
                    if (bus_in) begin
                        pend_d  = RES_ALARM;
                        state_d = ST_FILL;
                    end else begin
                        res_d   = RES_SHORT;
                        state_d = ST_REPORT;
                    end
                end
            end
            ST_FILL: begin
                if (expire) begin
                    res_d   = pend_q;
                    state_d = ST_REPORT;
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            spd_q   <= SPD_STD;
            res_q   <= RES_PRESENT;
            pend_q  <= RES_PRESENT;
        end else begin
            state_q <= state_d;
            spd_q   <= spd_d;
            res_q   <= res_d;
            pend_q  <= pend_d;
        end
    end

    // Outputs
    always_comb begin
        bus_pull_en = (state_q == ST_RST_LOW);
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_REPORT);
        result      = res_q;
    end

    // R10: done is a single-cycle strobe
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: result only moves together with done
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    // R1: the pull-down only begins after a start request
    a_r1_pull_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_pull_en) |-> $past(start));

    // R1: the pull-down is released only on a tick boundary
    a_r1_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_pull_en) |-> $past(tick_us));

    // R9: a start while busy never launches a new low phase
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !$rose(bus_pull_en));

    // R6: a short is reported straight from the recheck, without fill
    a_r6_short_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_SHORT) |-> $past(state_q) == ST_RECHECK);

    // R4: every other outcome is reported only after the fill period
    a_r4_fill_first: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != RES_SHORT) |-> $past(state_q) == ST_FILL);

endmodule

// File: tb/ow_reset_seq_tb.sv
module ow_reset_seq_tb;

    localparam int RC = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b0;
    logic       start = 1'b0;
    logic [1:0] speed = 2'b00;
    logic       bus_in = 1'b1;
    logic       bus_pull_en;
    logic       busy;
    logic       done;
    logic [1:0] result;

    int checks = 0;
    int errors = 0;
    int cyc_total = 0;
    bit wd_hit = 1'b0;

    always #5 clk = ~clk;

    ow_reset_seq #(.RECHECK_TICKS(RC)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_us    (tick_us),
        .start      (start),
        .speed      (speed),
        .bus_in     (bus_in),
        .bus_pull_en(bus_pull_en),
        .busy       (busy),
        .done       (done),
        .result     (result)
    );

    function automatic int t_low(int s);  return (s == 1) ? 64 : 512; endfunction
    function automatic int t_si(int s);   return (s == 1) ? 2  : 8;   endfunction
    function automatic int t_pd(int s);   return (s == 1) ? 8  : 64;  endfunction
    function automatic int t_fill(int s); return (s == 1) ? 64 : 512; endfunction

    // Slave model: line is low for release tick indices lo..hi
    function automatic bit line_at(int idx, int lo, int hi);
        if (idx < 1) return 1'b1;
        return !(idx >= lo && idx <= hi);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 190000 && !wd_hit) begin
            wd_hit = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run(int spd, int lo, int hi, bit inject, int gapmax, string tag);
        int  si, pd, fl, exp_res, exp_rel, low_c, rel_c, n;
        bit  s1, s2, tk;
        string rel_req, res_req;
        si = t_si(spd); pd = t_pd(spd); fl = t_fill(spd);
        s1 = line_at(si, lo, hi);
        if (s1) begin
            s2      = line_at(si + pd, lo, hi);
            exp_res = s2 ? 2 : 0;
            exp_rel = si + pd + fl;
            rel_req = "R4";
            res_req = "R3";
        end else begin
            s2      = line_at(si + RC, lo, hi);
            exp_res = s2 ? 1 : 3;
            exp_rel = s2 ? si + RC + fl : si + RC;
            rel_req = s2 ? "R5" : "R6";
            res_req = s2 ? "R7" : "R6";
        end
        low_c = 0; rel_c = 0; n = 0;
        @(negedge clk);
        start = 1'b1; speed = 2'(spd); tick_us = 1'b0; bus_in = 1'b1;
        @(negedge clk);
        start = 1'b0; speed = 2'($urandom);
        check(busy && bus_pull_en, {tag, " R1 pull after start"}, int'(bus_pull_en), 1);
        while (!done && n < 20000) begin
            tk = (gapmax == 0) ? 1'b1 : (($urandom % (gapmax + 1)) == 0);
            if (bus_pull_en) begin
                bus_in = 1'b0;
                if (tk) low_c++;
            end else begin
                bus_in = line_at(rel_c + int'(tk), lo, hi);
                if (tk) rel_c++;
            end
            if (inject && (n % 29) == 7) begin
                start = 1'b1;
                speed = 2'($urandom);
            end else begin
                start = 1'b0;
            end
            tick_us = tk;
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        tick_us = 1'b0;
        check(done == 1'b1, {tag, " R10 done seen"}, int'(done), 1);
        check(int'(result) == exp_res, {tag, " ", res_req, " result"}, int'(result), exp_res);
        check(low_c == t_low(spd), {tag, " R1 low ticks"}, low_c, t_low(spd));
        check(rel_c == exp_rel, {tag, " ", rel_req, " release-to-done ticks"}, rel_c, exp_rel);
        @(negedge clk);
        check(!done && !busy, {tag, " R10 strobe width"}, int'(done) + int'(busy), 0);
        check(int'(result) == exp_res, {tag, " R10 result held"}, int'(result), exp_res);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'h1A2B);
        repeat (3) @(negedge clk);
        check(!bus_pull_en && !busy && !done && result == 2'b00, "R11 reset state",
              int'({bus_pull_en, busy, done, result}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_pull_en && !busy && !done && result == 2'b00, "R11 after release",
              int'({bus_pull_en, busy, done, result}), 0);

        run(0, 1, 0, 0, 0, "D1 R3 regular empty");
        run(0, 9, 72, 0, 1, "D2 R3 regular presence");
        run(0, 20, 71, 0, 0, "D3 R3 window one tick early");
        run(0, 72, 72, 0, 0, "D4 R3 window on sample tick");
        run(0, 8, 8, 0, 0, "D5 R2 low on interrupt sample");
        run(0, 7, 7, 0, 0, "D6 R2 low one tick before sample");
        run(0, 1, 8 + RC - 1, 0, 1, "D7 R7 interrupt ends before recheck");
        run(0, 1, 8 + RC, 0, 0, "D8 R6 still low at recheck");
        run(1, 1, 1000000, 0, 1, "D9 R8 overdrive short");
        run(1, 1, 50, 0, 0, "D10 R8 overdrive alarm");
        run(1, 3, 10, 0, 0, "D11 R3 overdrive presence");
        run(2, 9, 80, 0, 1, "D12 R1 flexible presence");
        run(3, 1, 0, 0, 0, "D13 R1 code 11 as regular");
        run(0, 9, 72, 1, 1, "D14 R9 restart ignored");
        run(1, 1, 0, 1, 0, "D15 R9 overdrive speed latched");

        for (int i = 0; i < 22; i++) begin
            int s, k, si, pd, lo, hi;
            s  = int'($urandom % 4);
            si = t_si(s); pd = t_pd(s);
            k  = int'($urandom % 4);
            case (k)
                0: begin lo = 1; hi = 0; end
                1: begin lo = si + 1 + int'($urandom % pd); hi = si + pd + int'($urandom % 20); end
                2: begin lo = 1; hi = si + int'($urandom % RC); end
                default: begin lo = int'($urandom % (si + 1)) + 1; hi = 1000000; end
            endcase
            if (lo > si && k == 3) lo = si;
            run(s, lo, hi, ($urandom % 3) == 0, int'($urandom % 2), "RND");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule